// File: doc/BRIEF.md
# Capture Channel Interrupt Status Controller

This block gathers the events raised by a multi-channel camera capture engine into one 32-bit status word and drives a single level-sensitive interrupt line. Each capture channel reports five event kinds: frame begin, frame finish, frame finish acknowledged, line finish and line finish acknowledged. The engine as a whole reports five error kinds: overflow, and packets dropped because of overflow, length limit, no matching channel, or an inactive channel. Every event kind has its own 4-bit group in the status word, and the channel number picks the bit inside the group. The error kinds sit in the five bits above the channel groups.

Software reaches the block through a simple word-addressed register port with a combinational read. Word 0 is the status word. A write to it clears each bit that is written as one, so writing back a value just read acknowledges exactly the events that were seen. Word 1 is the error mask. Words 2 to 2+N-1 are the per-channel control words, and each holds the five event enables of its channel. An event is recorded only while its enable or mask bit is set. The interrupt line is registered and reflects whether any pending bit is currently enabled.

Top module: `cam_irq_status`

## Requirements
- R1: After reset the status word, the error mask, every channel control word and the interrupt output are all zero.
- R2: A channel event is recorded in status bit 4*k+c, where c is the channel and k is the event kind: 0 frame begin, 1 frame finish, 2 frame finish acknowledged, 3 line finish, 4 line finish acknowledged. It is recorded only when bit 13+k of the control word of channel c (register word 2+c) is set, and it reads back one clock edge after the event is sampled.
- R3: A channel event whose enable bit is clear leaves the status word unchanged.
- R4: Error input i (0 overflow, 1 dropped for overflow, 2 dropped for length, 3 dropped as unmatched, 4 dropped as inactive) sets status bit 20+i only when bit i of the error mask (register word 1) is set. With the mask at zero, no error is recorded.
- R5: A write to status word 0 clears every bit written as one and leaves the bits written as zero unchanged.
- R6: An event that arrives in the same cycle as a write clearing its bit leaves the bit set.
- R7: The interrupt output goes high one cycle after an enabled bit becomes pending, and goes low one cycle after the last enabled pending bit is cleared.
- R8: Status bits 31 to 25 read as zero. A control word reads back only bits 17 to 13, the mask word reads back only bits 4 to 0, and any unmapped address reads as zero.
- R9: Clearing the enable of a pending bit leaves that status bit set but removes it from the interrupt one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_fbeg | input | NUM_CH | Frame begin event, one bit per channel |
| evt_fend | input | NUM_CH | Frame finish event, one bit per channel |
| evt_fack | input | NUM_CH | Frame finish acknowledged event, one bit per channel |
| evt_lend | input | NUM_CH | Line finish event, one bit per channel |
| evt_lack | input | NUM_CH | Line finish acknowledged event, one bit per channel |
| err_evt | input | 5 | Error events, bit i maps to status bit 20+i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Registered level interrupt |

## Verification
The hardest case to reach is the same-cycle collision between an arriving event and a software write that clears the same bit. A dedicated task drives the event pulse and the write-one-to-clear strobe at the same falling edge so that a single rising edge samples both, and then reads the status word back. The same bench also checks the two-step timing of the interrupt: the status bit shows one edge after the event, and the line follows one edge after that. It checks the same delay when the line drops after a clear or after an enable is withdrawn.

// File: rtl/cam_irq_pkg.sv
package cam_irq_pkg;
   localparam int GROUPS      = 5;
   localparam int GROUP_W     = 4;
   localparam int ERR_N       = 5;
   localparam int REG_W       = 32;
   localparam int ERR_LSB     = GROUPS * GROUP_W;
   localparam int CAP_W       = ERR_LSB + ERR_N;
   localparam int CTRL_EN_LSB = 13;
   localparam int ADR_STATUS  = 0;
   localparam int ADR_MASK    = 1;
   localparam int ADR_CH0     = 2;

   typedef enum logic [2:0] {
      EV_FBEG = 3'd0,
      EV_FEND = 3'd1,
      EV_FACK = 3'd2,
      EV_LEND = 3'd3,
      EV_LACK = 3'd4
   } evt_kind_e;
endpackage

// File: rtl/cam_irq_cfg.sv
module cam_irq_cfg
   import cam_irq_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [CAP_W-1:0]  cap_en
);
   logic [ERR_N-1:0]  mask_q;
   logic [GROUPS-1:0] en_q [NUM_CH];
   logic              unused_cfg;

   assign unused_cfg = ^{wdata[REG_W-1:CTRL_EN_LSB+GROUPS], wdata[CTRL_EN_LSB-1:ERR_N]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
         for (int c = 0; c < NUM_CH; c++) en_q[c] <= '0;
      end else if (we) begin
         if (addr == ADDR_W'(ADR_MASK)) mask_q <= wdata[ERR_N-1:0];
         for (int c = 0; c < NUM_CH; c++)
            if (addr == ADDR_W'(ADR_CH0 + c)) en_q[c] <= wdata[CTRL_EN_LSB +: GROUPS];
      end
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      for (genvar c = 0; c < GROUP_W; c++) begin : g_ch
         if (c < NUM_CH) begin : g_live
            assign cap_en[g*GROUP_W + c] = en_q[c][g];
         end else begin : g_tie
            assign cap_en[g*GROUP_W + c] = 1'b0;
         end
      end
   end
   assign cap_en[ERR_LSB +: ERR_N] = mask_q;
endmodule

// File: rtl/cam_irq_sticky.sv
module cam_irq_sticky
   import cam_irq_pkg::*;
#(
   parameter int WIDTH = CAP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic [WIDTH-1:0] cap_en,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_bits,
   output logic [WIDTH-1:0] status_q
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) status_q[b] <= 1'b0;
         else        status_q[b] <= (status_q[b] & ~(clr_we & clr_bits[b]))
                                    | (evt[b] & cap_en[b]);
      end
   end
endmodule

// File: rtl/cam_irq_line.sv
module cam_irq_line
   import cam_irq_pkg::*;
#(
   parameter int WIDTH = CAP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] status,
   input  logic [WIDTH-1:0] cap_en,
   output logic             irq_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(status & cap_en);
   end
endmodule

// File: rtl/cam_irq_status.sv
module cam_irq_status
   import cam_irq_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_fbeg,
   input  logic [NUM_CH-1:0] evt_fend,
   input  logic [NUM_CH-1:0] evt_fack,
   input  logic [NUM_CH-1:0] evt_lend,
   input  logic [NUM_CH-1:0] evt_lack,
   input  logic [ERR_N-1:0]  err_evt,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);
   if (NUM_CH < 1 || NUM_CH > GROUP_W) begin : g_bad_ch
      $error("NUM_CH must lie between 1 and the group width");
   end
   if ((ADR_CH0 + NUM_CH) > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the channel control words");
   end

   logic [CAP_W-1:0] evt_vec;
   logic [CAP_W-1:0] cap_en;
   logic [CAP_W-1:0] status_q;
   logic             clr_we;

   for (genvar c = 0; c < GROUP_W; c++) begin : g_evt
      if (c < NUM_CH) begin : g_live
         assign evt_vec[EV_FBEG*GROUP_W + c] = evt_fbeg[c];
         assign evt_vec[EV_FEND*GROUP_W + c] = evt_fend[c];
         assign evt_vec[EV_FACK*GROUP_W + c] = evt_fack[c];
         assign evt_vec[EV_LEND*GROUP_W + c] = evt_lend[c];
         assign evt_vec[EV_LACK*GROUP_W + c] = evt_lack[c];
      end else begin : g_tie
         for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            assign evt_vec[g*GROUP_W + c] = 1'b0;
         end
      end
   end
   assign evt_vec[ERR_LSB +: ERR_N] = err_evt;

   assign clr_we = reg_we && (reg_addr == ADDR_W'(ADR_STATUS));

   cam_irq_cfg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .cap_en (cap_en)
   );

   cam_irq_sticky #(.WIDTH(CAP_W)) i_sticky (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_vec),
      .cap_en   (cap_en),
      .clr_we   (clr_we),
      .clr_bits (reg_wdata[CAP_W-1:0]),
      .status_q (status_q)
   );

   cam_irq_line #(.WIDTH(CAP_W)) i_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status_q),
      .cap_en (cap_en),
      .irq_q  (irq)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADR_STATUS)) begin
         reg_rdata[CAP_W-1:0] = status_q;
      end else if (reg_addr == ADDR_W'(ADR_MASK)) begin
         reg_rdata[ERR_N-1:0] = cap_en[ERR_LSB +: ERR_N];
      end else begin
         for (int c = 0; c < NUM_CH; c++)
            if (reg_addr == ADDR_W'(ADR_CH0 + c))
               for (int g = 0; g < GROUPS; g++)
                  reg_rdata[CTRL_EN_LSB + g] = cap_en[g*GROUP_W + c];
      end
   end
endmodule

// File: rtl/cam_irq_status_chk.sv
module cam_irq_status_chk
   import cam_irq_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_wdata,
   input logic [REG_W-1:0]  reg_rdata,
   input logic              irq,
   input logic [CAP_W-1:0]  evt_vec,
   input logic [CAP_W-1:0]  cap_en,
   input logic [CAP_W-1:0]  status_q
);
   localparam int CH_SPAN = NUM_CH;

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(ADR_STATUS)) |-> (reg_rdata[REG_W-1:CAP_W] == '0)); // R8

   AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(status_q != '0)); // R7

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(ADR_STATUS) && (&reg_wdata[CAP_W-1:0]) && evt_vec == '0)
      |=> (status_q == '0)); // R5

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_vec[0] && cap_en[0]) |=> status_q[0]); // R6

   AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_q[0] && !cap_en[0]) |=> !status_q[0]); // R3

   AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_q[ERR_LSB] && !cap_en[ERR_LSB]) |=> !status_q[ERR_LSB]); // R4

   AST_CTRL_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(ADR_CH0)) |-> (reg_rdata[CTRL_EN_LSB-1:0] == '0 && CH_SPAN > 0)); // R8
endmodule

bind cam_irq_status cam_irq_status_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .evt_vec   (evt_vec),
   .cap_en    (cap_en),
   .status_q  (status_q)
);

// File: tb/test_cam_irq_status.sv
module test_cam_irq_status;
   localparam int NCH = 4;
   localparam int AW  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [24:0] ev = '0;
   logic        we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   cam_irq_status #(.NUM_CH(NCH), .ADDR_W(AW)) i_cam_irq_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_fbeg  (ev[3:0]),
      .evt_fend  (ev[7:4]),
      .evt_fack  (ev[11:8]),
      .evt_lend  (ev[15:12]),
      .evt_lack  (ev[19:16]),
      .err_evt   (ev[24:20]),
      .reg_we    (we),
      .reg_addr  (addr),
      .reg_wdata (wdata),
      .reg_rdata (rdata),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   task automatic pulse(input logic [24:0] v);
      @(negedge clk);
      ev = v;
      @(negedge clk);
      ev = '0;
   endtask

   task automatic clear_all();
      wr(0, 32'h01FF_FFFF);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(0, d); chk("R1 status", d, 32'h0);
      rd(1, d); chk("R1 mask", d, 32'h0);
      for (int c = 0; c < NCH; c++) begin
         rd(2 + c, d); chk("R1 ctrl", d, 32'h0);
      end
      chk("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_chan_map();
      logic [31:0] d;
      for (int c = 0; c < NCH; c++) wr(2 + c, 32'h0003_E000);
      for (int k = 0; k < 5; k++)
         for (int c = 0; c < NCH; c++) begin
            pulse(25'(1) << (4*k + c));
            rd(0, d); chk("R2 bit position", d, 32'(1) << (4*k + c));
            wr(0, d);
            rd(0, d); chk("R5 write back clears", d, 32'h0);
         end
      @(negedge clk);
   endtask

   task automatic t_disabled();
      logic [31:0] d;
      for (int c = 0; c < NCH; c++) wr(2 + c, 32'h0);
      wr(3, 32'h0000_2000);
      pulse(25'h0000_0020);
      rd(0, d); chk("R3 frame finish ch1 disabled", d, 32'h0);
      pulse(25'h0000_0004);
      rd(0, d); chk("R3 frame begin ch2 disabled", d, 32'h0);
      pulse(25'h000F_FFFD);
      rd(0, d); chk("R3 only enabled bit", d, 32'h0);
      pulse(25'h0000_0002);
      rd(0, d); chk("R2 enabled ch1 frame begin", d, 32'h2);
      clear_all();
   endtask

   task automatic t_err_mask();
      logic [31:0] d;
      wr(1, 32'h0);
      pulse(25'h1F0_0000);
      rd(0, d); chk("R4 mask zero", d, 32'h0);
      wr(1, 32'h0000_0005);
      pulse(25'h1F0_0000);
      rd(0, d); chk("R4 partial mask", d, 32'h0050_0000);
      clear_all();
      wr(1, 32'h0);
   endtask

   task automatic t_partial_clear();
      logic [31:0] d;
      for (int c = 0; c < NCH; c++) wr(2 + c, 32'h0003_E000);
      wr(1, 32'h1F);
      pulse(25'h1A0_8421);
      rd(0, d); chk("R2 multi set", d, 32'h01A0_8421);
      wr(0, 32'h0020_0401);
      rd(0, d); chk("R5 partial clear", d, 32'h0180_8020);
      clear_all();
   endtask

   task automatic t_race();
      logic [31:0] d;
      pulse(25'h0000_0003);
      @(negedge clk);
      we = 1'b1; addr = '0; wdata = 32'h3; ev = 25'h1;
      @(negedge clk);
      we = 1'b0; ev = '0;
      rd(0, d); chk("R6 event beats clear", d, 32'h1);
      clear_all();
   endtask

   task automatic t_irq_timing();
      logic [31:0] d;
      chk("R7 idle low", {31'b0, irq}, 32'h0);
      pulse(25'h0001_0000);
      rd(0, d); chk("R7 status first", d, 32'h0001_0000);
      chk("R7 not yet", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R7 asserted", {31'b0, irq}, 32'h1);
      wr(0, 32'h0001_0000);
      chk("R7 still high after clear edge", {31'b0, irq}, 32'h1);
      @(negedge clk);
      chk("R7 released", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_reserved();
      logic [31:0] d;
      wr(2, 32'hFFFF_FFFF);
      rd(2, d); chk("R8 ctrl readback", d, 32'h0003_E000);
      wr(1, 32'hFFFF_FFFF);
      rd(1, d); chk("R8 mask readback", d, 32'h0000_001F);
      rd(9, d); chk("R8 unmapped", d, 32'h0);
      pulse(25'h1FF_FFFF);
      rd(0, d); chk("R8 top bits zero", d, 32'h01FF_FFFF);
      clear_all();
   endtask

   task automatic t_enable_gate();
      logic [31:0] d;
      wr(3, 32'h0000_4000);
      pulse(25'h0000_0020);
      @(negedge clk);
      chk("R9 irq from ch1", {31'b0, irq}, 32'h1);
      wr(3, 32'h0);
      chk("R9 irq one edge late", {31'b0, irq}, 32'h1);
      @(negedge clk);
      chk("R9 irq dropped", {31'b0, irq}, 32'h0);
      rd(0, d); chk("R9 status kept", d, 32'h0000_0020);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_chan_map();
      t_disabled();
      t_err_mask();
      t_partial_clear();
      t_race();
      t_irq_timing();
      t_reserved();
      t_enable_gate();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule